// File: doc/BRIEF.md
# Receive Character Framer with Stop-Bit Deletion Tolerance

This block sits after the demodulator in a modem receive path and turns a serial bit stream into bytes for a host. The demodulator presents one bit per cycle in which `bit_valid` is high. In synchronous mode every bit is packed and a byte is delivered after each eighth bit. In start-stop mode the block finds each character, collects 5 to 8 data bits (LSB first), optionally takes a parity bit, and then examines the stop bit.

Every delivered character lands in a host-readable register and raises a data-ready flag. An overflow flag warns that a character was replaced before the host read it. A framing-error flag and an even-parity flag describe the last start-stop character. One host read strobe clears ready and overflow.

Transmitters running slightly fast may delete a stop bit now and then. A selectable overspeed setting grants a budget of deleted stop bits. Within that budget, the zero found in the stop position is taken as the next character's start bit and no error is reported.

Top module: `rx_framer`

## Requirements
- R1: With `mode_async`=0, each bit with `bit_valid` high shifts in LSB first. Each eighth bit copies the byte to `rx_data`, visible on the cycle after that bit's strobe.
- R2: With `mode_async`=1, a character starts only on a 0 that follows a received 1. It then takes N = `data_bits`+5 data bits LSB first, with unused upper bits of `rx_data` reading 0. A parity bit follows when `parity_en`=1, and then the stop bit, whose strobe delivers the character.
- R3: Every delivery sets `data_ready`. A `rd_strobe` in a cycle without a delivery clears `data_ready` and `overflow`.
- R4: A delivery while `data_ready` is 1 and `rd_strobe` is 0 sets `overflow`. A delivery in the same cycle as `rd_strobe` leaves `data_ready`=1 and `overflow`=0.
- R5: On each start-stop delivery, `even_parity` becomes 1 when `parity_en`=1 and the data bits plus the parity bit hold an even number of ones. Otherwise it becomes 0. Synchronous deliveries leave it unchanged.
- R6: A stop bit received as 0 and not covered by the budget still delivers the character and sets `framing_err`. The framer then waits for a 1 followed by a 0 before starting the next character.
- R7: `framing_err` keeps its value until the next delivery. Any delivery that is not an uncovered deletion clears it, in either mode.
- R8: With `overspeed`=01, a 0 stop bit is covered when none of the previous 7 characters had a covered deletion. The 0 then acts as the next start bit, so the next strobe is data bit 0, and `framing_err` is cleared.
- R9: With `overspeed`=10, the covered window is the previous 3 characters. With `overspeed`=00 or 11, no deletion is covered.
- R10: Any change of `mode_async` or `overspeed` clears the deletion history and returns the framer to hunting for a 1 followed by a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `rx_bit` holds a new bit |
| rx_bit | input | 1 | Demodulated data bit |
| mode_async | input | 1 | 1 = start-stop, 0 = synchronous |
| data_bits | input | 2 | Data bits per character minus 5 |
| parity_en | input | 1 | A parity bit follows the data bits |
| overspeed | input | 2 | 00 none, 01 one deletion in 8, 10 one in 4 |
| rd_strobe | input | 1 | Host read of `rx_data` |
| rx_data | output | 8 | Last delivered character |
| data_ready | output | 1 | Unread character present |
| overflow | output | 1 | Character replaced before being read |
| framing_err | output | 1 | Last character had an uncovered stop deletion |
| even_parity | output | 1 | Data plus parity bit had even weight |

## Verification
The two functions that can fall in the same cycle are a delivery of a new character and a host read. A delivery sets `data_ready` and may set `overflow`, while a read clears both. The bench provokes the collision by raising `rd_strobe` on the strobe of the eighth synchronous bit while an unread byte is pending. It expects the new byte with ready set and no overflow. Sweeps over every data value for each character length and parity setting judge framing and parity arithmetically. Deletion sequences placed just inside and just outside each budget window check the tolerance logic, including a budget reset caused by a configuration change.

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
module rx_framer #(
  parameter int HIST = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       rx_bit,
  input  logic       mode_async,
  input  logic [1:0] data_bits,
  input  logic       parity_en,
  input  logic [1:0] overspeed,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overflow,
  output logic       framing_err,
  output logic       even_parity
);
  typedef enum logic [1:0] {S_HUNT, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic            armed;
  logic [2:0]      cnt;
  logic [7:0]      sh;
  logic            par_acc;
  logic            pbit;
  logic [HIST-1:0] hist;
  logic [2:0]      cfg_q;

  wire       cfg_chg  = {mode_async, overspeed} != cfg_q;
  wire       tick     = bit_valid && !cfg_chg;
  wire [2:0] last_idx = 3'd4 + {1'b0, data_bits};
  wire [HIST-1:0] win = (overspeed == 2'b01) ? {HIST{1'b1}} :
                        (overspeed == 2'b10) ? {{(HIST-3){1'b0}}, 3'b111} : '0;
  wire       allow    = (overspeed == 2'b01 || overspeed == 2'b10) && ((hist & win) == '0);
  wire       sync_del = tick && !mode_async && cnt == 3'd7;
  wire       ss_del   = tick && mode_async && st == S_STOP;
  wire       deliver  = sync_del || ss_del;
  wire       deleted  = ss_del && !rx_bit;
  wire       ok_del   = deleted && allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; armed <= 1'b0; cnt <= '0; sh <= '0;
      par_acc <= 1'b0; pbit <= 1'b0; hist <= '0; cfg_q <= '0;
    end else begin
      cfg_q <= {mode_async, overspeed};
      if (cfg_chg) begin
        hist <= '0; st <= S_HUNT; armed <= 1'b0; cnt <= '0;
      end else if (bit_valid) begin
        if (!mode_async) begin
          sh  <= {rx_bit, sh[7:1]};
          cnt <= cnt + 3'd1;
        end else begin
          case (st)
            S_HUNT:
              if (armed && !rx_bit) begin
                st <= S_DATA; cnt <= '0; sh <= '0; par_acc <= 1'b0;
              end else armed <= rx_bit;
            S_DATA: begin
              sh[cnt] <= rx_bit;
              par_acc <= par_acc ^ rx_bit;
              cnt     <= cnt + 3'd1;
              if (cnt == last_idx) st <= parity_en ? S_PAR : S_STOP;
            end
            S_PAR: begin
              pbit <= rx_bit;
              st   <= S_STOP;
            end
            default: begin
              hist <= {hist[HIST-2:0], ok_del};
              if (rx_bit) begin
                st <= S_HUNT; armed <= 1'b1;
              end else if (ok_del) begin
                st <= S_DATA; cnt <= '0; sh <= '0; par_acc <= 1'b0;
              end else begin
                st <= S_HUNT; armed <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; data_ready <= 1'b0; overflow <= 1'b0;
      framing_err <= 1'b0; even_parity <= 1'b0;
    end else if (deliver) begin
      rx_data     <= mode_async ? sh : {rx_bit, sh[7:1]};
      data_ready  <= 1'b1;
      overflow    <= data_ready && !rd_strobe;
      framing_err <= deleted && !allow;
      if (ss_del) even_parity <= parity_en && !(par_acc ^ pbit);
    end else if (rd_strobe) begin
      data_ready <= 1'b0;
      overflow   <= 1'b0;
    end
  end

  AST_READY_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> data_ready); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !deliver) |=> (!data_ready && !overflow)); // R3
  AST_OVF_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(data_ready)); // R4
  AST_FE_ASYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framing_err) |-> $past(mode_async)); // R6
  AST_SYNC_KEEPS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_async |=> $stable(even_parity)); // R5
  AST_BUDGET_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (overspeed == 2'b01 && !cfg_chg) |-> $countones(hist) <= 1); // R8
  AST_BUDGET_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (overspeed == 2'b10 && !cfg_chg) |-> $countones(hist[2:0]) <= 1); // R9
endmodule

// File: tb/rx_framer_bench.sv
`timescale 1ns/1ps
module rx_framer_bench;
  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, rx_bit = 1'b0;
  logic mode_async = 1'b0, parity_en = 1'b0, rd_strobe = 1'b0;
  logic [1:0] data_bits = 2'd3, overspeed = 2'd0;
  logic [7:0] rx_data;
  logic data_ready, overflow, framing_err, even_parity;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  rx_framer u_rx_framer (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .mode_async(mode_async), .data_bits(data_bits), .parity_en(parity_en),
    .overspeed(overspeed), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .data_ready(data_ready), .overflow(overflow), .framing_err(framing_err),
    .even_parity(even_parity));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, input logic rd = 1'b0);
    @(negedge clk); bit_valid = 1'b1; rx_bit = b; rd_strobe = rd;
    @(negedge clk); bit_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input int n, input logic pe,
                           input logic pb, input logic stopb, input logic wstart);
    if (wstart) bitx(1'b0);
    for (int i = 0; i < n; i++) bitx(d[i]);
    if (pe) bitx(pb);
    bitx(stopb);
  endtask

  task automatic set_cfg(input logic m, input logic [1:0] os);
    @(negedge clk); mode_async = m; overspeed = os;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic sync_byte(input logic [7:0] d, input logic rd_last);
    for (int i = 0; i < 8; i++) bitx(d[i], rd_last && i == 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset ready", data_ready, 0);
    chk("R4 reset overflow", overflow, 0);
    chk("R7 reset framing", framing_err, 0);

    // R1 synchronous packing and R4 overflow / collision
    set_cfg(1'b0, 2'd0);
    sync_byte(8'hA5, 1'b0);
    chk("R1 sync byte", rx_data, 8'hA5);
    chk("R3 sync ready", data_ready, 1);
    sync_byte(8'h3C, 1'b0);
    chk("R1 sync second byte", rx_data, 8'h3C);
    chk("R4 overflow set", overflow, 1);
    rd();
    chk("R3 read clears ready", data_ready, 0);
    chk("R3 read clears overflow", overflow, 0);
    sync_byte(8'h11, 1'b0);
    sync_byte(8'h22, 1'b1);
    chk("R4 collision data", rx_data, 8'h22);
    chk("R4 collision ready", data_ready, 1);
    chk("R4 collision overflow", overflow, 0);
    rd();
    for (int v = 0; v < 256; v++) begin
      sync_byte(v[7:0], 1'b0);
      chk("R1 sync sweep", rx_data, v);
      chk("R5 sync leaves parity flag", even_parity, 0);
      rd();
    end

    // R2 hunt needs a 1 before the start bit
    set_cfg(1'b1, 2'd0);
    data_bits = 2'd3; parity_en = 1'b0;
    for (int i = 0; i < 10; i++) bitx(1'b0);
    chk("R2 no start without prior one", data_ready, 0);

    // R2 / R5 sweep over lengths, parity and values
    for (int n = 5; n <= 8; n++) begin
      for (int pe = 0; pe < 2; pe++) begin
        data_bits = 2'(n - 5); parity_en = pe[0];
        for (int v = 0; v < (1 << n); v++) begin
          logic [7:0] d;
          logic pb;
          d = v[7:0];
          pb = d[n-1] ^ d[0];
          bitx(1'b1);
          send_char(d, n, pe[0], pb, 1'b1, 1'b1);
          chk("R2 char data", rx_data, v);
          chk("R3 char ready", data_ready, 1);
          chk("R7 framing clear", framing_err, 0);
          chk("R5 even parity", even_parity, pe ? int'(!((^d) ^ pb)) : 0);
          rd();
        end
      end
    end

    // R6 missing stop with no allowance, then resync
    data_bits = 2'd3; parity_en = 1'b0;
    bitx(1'b1);
    send_char(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 data still delivered", rx_data, 8'h5A);
    chk("R6 ready", data_ready, 1);
    chk("R6 framing set", framing_err, 1);
    rd();
    chk("R7 framing kept over read", framing_err, 1);
    for (int i = 0; i < 12; i++) bitx(1'b0);
    chk("R6 waits for one then zero", data_ready, 0);
    bitx(1'b1);
    send_char(8'h33, 8, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 next char clears framing", framing_err, 0);
    chk("R6 resync data", rx_data, 8'h33);
    rd();

    // R8 one in eight
    set_cfg(1'b1, 2'b01);
    bitx(1'b1);
    send_char(8'hC1, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 covered deletion framing", framing_err, 0);
    chk("R8 covered deletion data", rx_data, 8'hC1);
    rd();
    send_char(8'h92, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 zero acted as start", rx_data, 8'h92);
    rd();
    for (int k = 0; k < 5; k++) begin
      send_char(8'(k + 8'h40), 8, 1'b0, 1'b0, 1'b1, 1'b1);
      rd();
    end
    send_char(8'h77, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 second deletion within eight", framing_err, 1);
    rd();
    bitx(1'b1);
    send_char(8'h66, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 deletion after window", framing_err, 0);
    rd();
    send_char(8'h99, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 following char", rx_data, 8'h99);
    rd();

    // R9 one in four
    set_cfg(1'b1, 2'b10);
    bitx(1'b1);
    send_char(8'h01, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 first deletion", framing_err, 0);
    rd();
    send_char(8'h02, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    rd();
    send_char(8'h03, 8, 1'b0, 1'b0, 1'b1, 1'b1);
    rd();
    send_char(8'h04, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 deletion within four", framing_err, 1);
    rd();
    bitx(1'b1);
    send_char(8'h05, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 deletion after three clean", framing_err, 0);
    rd();
    send_char(8'h06, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 following char", rx_data, 8'h06);
    rd();

    // R10 config change clears history
    set_cfg(1'b1, 2'b01);
    bitx(1'b1);
    send_char(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    rd();
    send_char(8'h82, 8, 1'b0, 1'b0, 1'b1, 1'b0);
    rd();
    set_cfg(1'b1, 2'b10);
    set_cfg(1'b1, 2'b01);
    bitx(1'b1);
    send_char(8'h83, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 history cleared", framing_err, 0);
    chk("R10 data", rx_data, 8'h83);
    rd();

    // R7 synchronous delivery clears framing error
    set_cfg(1'b1, 2'b00);
    bitx(1'b1);
    send_char(8'h44, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 framing before switch", framing_err, 1);
    set_cfg(1'b0, 2'b00);
    sync_byte(8'hE7, 1'b0);
    chk("R7 sync clears framing", framing_err, 0);
    chk("R1 byte after switch", rx_data, 8'hE7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule